// File: doc/BRIEF.md
# Word-Load Instruction Field Decoder

This block is a purely combinational decoder for the word-load family of a compact 16/32-bit mixed-length instruction set. It receives one instruction word and a flag that says whether the word is a 16-bit or a 32-bit encoding. A third input says whether the instruction sits inside a conditional block and is not the last instruction in it. The block recognises eight load forms: four 16-bit forms and four 32-bit forms. The 16-bit forms are immediate, stack-pointer-relative, literal and register-offset. The 32-bit forms are 12-bit immediate, 8-bit immediate with pre/post-index and writeback control, literal and register-offset with shift.

For the matched form the decoder outputs the following fields:
- the base, destination and offset register indices;
- a zero-extended 32-bit offset;
- a left-shift amount;
- the index, add and writeback controls.

Every recognised word also gets a status: valid, belongs-to-another-instruction, undefined, or unpredictable. The decoder further outputs a form tag and a flag that marks 32-bit encodings which have a 16-bit equivalent. An execute stage uses all of this to build the memory access. Fetch, the register file and the memory access itself are handled elsewhere.

Top module: `ldw_dec`

## Requirements
- R1: 16-bit mode, `insn_i[15:11]==5'b01101`: form 1; rt=`[2:0]`, rn=`[5:3]`, imm=`[10:6]*4`; index=1, add=1, wback=0; status valid.
- R2: 16-bit mode, `insn_i[15:11]==5'b10011`: form 2; rn=13 (stack pointer), rt=`[10:8]`, imm=`[7:0]*4`; index=1, add=1, wback=0.
- R3: Literal forms, base reported as rn=15, index=1, wback=0.
  - 16-bit `[15:11]==5'b01001`: form 3; rt=`[10:8]`, imm=`[7:0]*4`, add=1.
  - 32-bit `[31:24]==8'hF8` with `[22:16]==7'h5F`: form 7; rt=`[15:12]`, imm=`[11:0]`, add=`[23]`.
  - The 32-bit literal pattern takes priority over every other 32-bit form, so a 32-bit word whose base field is 15 decodes as literal.
- R4: 32-bit `[31:20]==12'hF8D`: form 5; rn=`[19:16]`, rt=`[15:12]`, imm=`[11:0]` unscaled, index=1, add=1, wback=0.
- R5: 32-bit `[31:20]==12'hF85` with `[11]=1`: form 6; rn=`[19:16]`, rt=`[15:12]`, index=`[10]`, add=`[9]`, wback=`[8]`, imm=`[7:0]`.
  - Status other when `[10:8]==3'b110`, or when rn=13, `[10:8]==3'b011` and imm=4.
  - Otherwise undefined when `[10]` and `[8]` are both 0.
- R6: Unpredictable status applies, unless R5 already gives other or undefined, when any of these holds:
  - form 6 with writeback set and rn equal to rt;
  - any 32-bit form with rt=15 and `it_mid_i=1`;
  - form 8 with rm equal to 13 or 15.
- R7: Register-offset forms.
  - 16-bit `[15:9]==7'b0101100`: form 4; rm=`[8:6]`, rn=`[5:3]`, rt=`[2:0]`, shift 0.
  - 32-bit `[31:20]==12'hF85` with `[11:6]==0`: form 8; rn=`[19:16]`, rt=`[15:12]`, rm=`[3:0]`, shift=`[5:4]`.
  - Both forms have index=1, add=1, wback=0.
- R8: Status encoding is 0 valid, 1 other, 2 undefined, 3 unpredictable. The 16-bit forms are always valid, and `it_mid_i` has no effect on them. Fields not used by a form are zero.
- R9: When no form matches, `no_match_o=1` and every other output is zero. In 16-bit mode the upper half of `insn_i` is ignored.
- R10: `wide_qual_o` is 1 exactly for forms 5, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word; 16-bit encodings use bits [15:0] |
| wide_i | input | 1 | 1 = 32-bit encoding, 0 = 16-bit encoding |
| it_mid_i | input | 1 | Inside a conditional block and not its last instruction |
| no_match_o | output | 1 | No word-load form matched |
| form_o | output | 4 | Form tag 0..8 (0 = none) |
| status_o | output | 2 | 0 valid, 1 other, 2 undefined, 3 unpredictable |
| wide_qual_o | output | 1 | 32-bit form that has a 16-bit equivalent |
| rn_o | output | 4 | Base register index |
| rt_o | output | 4 | Destination register index |
| rm_o | output | 4 | Offset register index |
| imm_o | output | 32 | Zero-extended offset |
| shamt_o | output | 2 | Left-shift amount applied to the offset register |
| index_o | output | 1 | Offset applied before the access |
| add_o | output | 1 | Offset added (1) or subtracted (0) |
| wback_o | output | 1 | Base register updated |

## Verification
The hardest status cases to reach are the stack-pop alias and the bit-pattern overlaps between forms.
- The pop alias needs four fields to agree at once in the 8-bit-immediate form: base 13, control bits 011 and offset exactly 4.
- The overlaps include a 32-bit word with base 15, which must fall to the literal form rather than the immediate forms.

Uniform random words almost never produce these, so the bench does two things. First, it builds random words by forcing each form's fixed prefix and randomising only the free fields. Second, it adds directed words for the pop alias, the other-instruction and undefined control values, writeback with equal registers, and a destination of 15 inside a conditional block.

// File: rtl/ldw_pkg.sv
// Shared widths, form tags, status codes and the decoded-field record
// for the word-load decoder. Assumes 16 architectural registers.
package ldw_pkg;
    parameter int INSN_W = 32;
    parameter int HALF_W = 16;
    parameter int REG_W  = 4;
    parameter int IMM_W  = 32;
    parameter int SH_W   = 2;

    localparam logic [REG_W-1:0] REG_SP = REG_W'(13);
    localparam logic [REG_W-1:0] REG_PC = REG_W'(15);

    typedef enum logic [3:0] {
        FORM_NONE  = 4'd0,
        FORM_IMM5  = 4'd1,
        FORM_SP8   = 4'd2,
        FORM_LIT8  = 4'd3,
        FORM_REG16 = 4'd4,
        FORM_IMM12 = 4'd5,
        FORM_IMM8  = 4'd6,
        FORM_LIT12 = 4'd7,
        FORM_REG32 = 4'd8
    } form_e;

    typedef enum logic [1:0] {
        ST_VALID  = 2'd0,
        ST_OTHER  = 2'd1,
        ST_UNDEF  = 2'd2,
        ST_UNPRED = 2'd3
    } status_e;

    typedef struct packed {
        form_e             form;
        status_e           status;
        logic [REG_W-1:0]  rn;
        logic [REG_W-1:0]  rt;
        logic [REG_W-1:0]  rm;
        logic [IMM_W-1:0]  imm;
        logic [SH_W-1:0]   shamt;
        logic              index;
        logic              add;
        logic              wback;
    } dec_t;
endpackage

// File: rtl/ldw_narrow_dec.sv
// Decodes the four 16-bit word-load forms from a halfword.
// Assumes the caller already knows the word is a 16-bit encoding.
// All 16-bit forms are valid; unmatched halfwords give an all-zero record.
module ldw_narrow_dec
    import ldw_pkg::*;
(
    input  logic [HALF_W-1:0] hw_i,
    output dec_t              dec_o
);
    localparam int LO_REG_W = 3;

    // Match one of the four prefixes and extract its fields.
    always_comb begin
        dec_o = '0;
        if (hw_i[15:11] == 5'b01101) begin
            dec_o.form  = FORM_IMM5;
            dec_o.rt    = REG_W'(hw_i[2:0]);
            dec_o.rn    = REG_W'(hw_i[5:3]);
            dec_o.imm   = IMM_W'({hw_i[10:6], 2'b00});
            dec_o.index = 1'b1;
            dec_o.add   = 1'b1;
        end else if (hw_i[15:11] == 5'b10011) begin
            dec_o.form  = FORM_SP8;
            dec_o.rn    = REG_SP;
            dec_o.rt    = REG_W'(hw_i[10:8]);
            dec_o.imm   = IMM_W'({hw_i[7:0], 2'b00});
            dec_o.index = 1'b1;
            dec_o.add   = 1'b1;
        end else if (hw_i[15:11] == 5'b01001) begin
            dec_o.form  = FORM_LIT8;
            dec_o.rn    = REG_PC;
            dec_o.rt    = REG_W'(hw_i[10:8]);
            dec_o.imm   = IMM_W'({hw_i[7:0], 2'b00});
            dec_o.index = 1'b1;
            dec_o.add   = 1'b1;
        end else if (hw_i[15:9] == 7'b0101100) begin
            dec_o.form  = FORM_REG16;
            dec_o.rm    = REG_W'(hw_i[6 +: LO_REG_W]);
            dec_o.rn    = REG_W'(hw_i[3 +: LO_REG_W]);
            dec_o.rt    = REG_W'(hw_i[0 +: LO_REG_W]);
            dec_o.index = 1'b1;
            dec_o.add   = 1'b1;
        end
    end
endmodule

// File: rtl/ldw_wide_class.sv
// Classifies a matched 32-bit word-load form as valid, other-instruction,
// undefined or unpredictable. Precedence: other, undefined, unpredictable.
// Assumes form_i is one of the 32-bit forms or FORM_NONE.
module ldw_wide_class
    import ldw_pkg::*;
(
    input  form_e            form_i,
    input  logic [2:0]       ctl_i,
    input  logic [REG_W-1:0] rn_i,
    input  logic [REG_W-1:0] rt_i,
    input  logic [REG_W-1:0] rm_i,
    input  logic [7:0]       off8_i,
    input  logic             it_mid_i,
    output status_e          status_o
);
    logic pc_dest_hazard;
    logic is_other;
    logic is_undef;
    logic is_unpred;

    // Evaluate each class condition separately for the selected form.
    always_comb begin
        pc_dest_hazard = (rt_i == REG_PC) && it_mid_i;
        is_other  = 1'b0;
        is_undef  = 1'b0;
        is_unpred = 1'b0;
        unique case (form_i)
            FORM_IMM8: begin
                is_other  = (ctl_i == 3'b110) ||
                            ((rn_i == REG_SP) && (ctl_i == 3'b011) && (off8_i == 8'd4));
                is_undef  = !ctl_i[2] && !ctl_i[0];
                is_unpred = (ctl_i[0] && (rn_i == rt_i)) || pc_dest_hazard;
            end
            FORM_IMM12, FORM_LIT12: is_unpred = pc_dest_hazard;
            FORM_REG32: is_unpred = (rm_i == REG_SP) || (rm_i == REG_PC) || pc_dest_hazard;
            default: ;
        endcase
    end

    // Resolve the classes in priority order.
    always_comb begin
        if (is_other)       status_o = ST_OTHER;
        else if (is_undef)  status_o = ST_UNDEF;
        else if (is_unpred) status_o = ST_UNPRED;
        else                status_o = ST_VALID;
    end
endmodule

// File: rtl/ldw_wide_dec.sv
// Decodes the four 32-bit word-load forms. The literal pattern is tested
// first, so a base field of 15 in the other forms always decodes as literal.
// Unmatched words give an all-zero record.
module ldw_wide_dec
    import ldw_pkg::*;
(
    input  logic [INSN_W-1:0] w_i,
    input  logic              it_mid_i,
    output dec_t              dec_o
);
    dec_t    fields;
    status_e cls;

    // Pattern match and field extraction.
    always_comb begin
        fields = '0;
        if (w_i[31:24] == 8'hF8 && w_i[22:16] == 7'h5F) begin
            fields.form  = FORM_LIT12;
            fields.rn    = REG_PC;
            fields.rt    = w_i[15:12];
            fields.imm   = IMM_W'(w_i[11:0]);
            fields.index = 1'b1;
            fields.add   = w_i[23];
        end else if (w_i[31:20] == 12'hF8D) begin
            fields.form  = FORM_IMM12;
            fields.rn    = w_i[19:16];
            fields.rt    = w_i[15:12];
            fields.imm   = IMM_W'(w_i[11:0]);
            fields.index = 1'b1;
            fields.add   = 1'b1;
        end else if (w_i[31:20] == 12'hF85 && w_i[11]) begin
            fields.form  = FORM_IMM8;
            fields.rn    = w_i[19:16];
            fields.rt    = w_i[15:12];
            fields.imm   = IMM_W'(w_i[7:0]);
            fields.index = w_i[10];
            fields.add   = w_i[9];
            fields.wback = w_i[8];
        end else if (w_i[31:20] == 12'hF85 && w_i[11:6] == 6'd0) begin
            fields.form  = FORM_REG32;
            fields.rn    = w_i[19:16];
            fields.rt    = w_i[15:12];
            fields.rm    = w_i[3:0];
            fields.shamt = w_i[5:4];
            fields.index = 1'b1;
            fields.add   = 1'b1;
        end
    end

    ldw_wide_class u_class (
        .form_i   (fields.form),
        .ctl_i    (w_i[10:8]),
        .rn_i     (fields.rn),
        .rt_i     (fields.rt),
        .rm_i     (fields.rm),
        .off8_i   (w_i[7:0]),
        .it_mid_i (it_mid_i),
        .status_o (cls)
    );

    // Attach the status to the field record.
    always_comb begin
        dec_o        = fields;
        dec_o.status = cls;
    end
endmodule

// File: rtl/ldw_dec.sv
// Top of the word-load decoder: selects the 16-bit or 32-bit sub-decoder,
// flags no-match and the wide qualifier. Purely combinational, so it has
// no clock or reset; callers register the outputs in their own stage.
module ldw_dec
    import ldw_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic        wide_i,
    input  logic        it_mid_i,
    output logic        no_match_o,
    output logic [3:0]  form_o,
    output logic [1:0]  status_o,
    output logic        wide_qual_o,
    output logic [3:0]  rn_o,
    output logic [3:0]  rt_o,
    output logic [3:0]  rm_o,
    output logic [31:0] imm_o,
    output logic [1:0]  shamt_o,
    output logic        index_o,
    output logic        add_o,
    output logic        wback_o
);
    dec_t nd;
    dec_t wd;
    dec_t sel;

    ldw_narrow_dec u_narrow (.hw_i(insn_i[HALF_W-1:0]), .dec_o(nd));
    ldw_wide_dec   u_wide   (.w_i(insn_i), .it_mid_i(it_mid_i), .dec_o(wd));

    // Choose the sub-decoder for the encoding length and drive the ports.
    always_comb begin
        sel         = wide_i ? wd : nd;
        no_match_o  = (sel.form == FORM_NONE);
        form_o      = sel.form;
        status_o    = sel.status;
        wide_qual_o = wide_i && (sel.form == FORM_IMM12 || sel.form == FORM_LIT12 ||
                                 sel.form == FORM_REG32);
        rn_o        = sel.rn;
        rt_o        = sel.rt;
        rm_o        = sel.rm;
        imm_o       = sel.imm;
        shamt_o     = sel.shamt;
        index_o     = sel.index;
        add_o       = sel.add;
        wback_o     = sel.wback;
    end

    // Cross-checks between the sub-decoders and the ports.
    always_comb begin
        assert_narrow_valid_R8: assert (wide_i || status_o == 2'd0)
            else $error("16-bit form reported non-valid status");
        assert_nomatch_zero_R9: assert (!no_match_o ||
                (imm_o == '0 && rn_o == '0 && rt_o == '0 && rm_o == '0 &&
                 status_o == '0 && !index_o && !add_o && !wback_o && !wide_qual_o))
            else $error("no-match with non-zero fields");
        assert_undef_ctl_R5: assert (status_o != 2'd2 ||
                (wide_i && !insn_i[10] && !insn_i[8] && form_o == 4'd6))
            else $error("undefined status outside 8-bit-immediate P=W=0");
        assert_wback_form_R5: assert (!wback_o || (wide_i && form_o == 4'd6))
            else $error("writeback from a form without it");
        assert_qual_wide_R10: assert (!wide_qual_o || wide_i)
            else $error("wide qualifier on a 16-bit word");
        assert_narrow_lowregs_R1: assert (wide_i ||
                !(form_o == 4'd1 || form_o == 4'd4) || (rn_o < 4'd8 && rt_o < 4'd8))
            else $error("16-bit register field out of range");
    end
endmodule

// File: tb/ldw_dec_bench.sv
module ldw_dec_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [31:0] insn;
    logic        wide;
    logic        itm;
    logic        no_match, wide_qual, index_f, add_f, wback_f;
    logic [3:0]  form, rn, rt, rm;
    logic [1:0]  status, shamt;
    logic [31:0] imm;

    int n_checks = 0;
    int n_fail   = 0;

    ldw_dec u_ldw_dec (
        .insn_i(insn), .wide_i(wide), .it_mid_i(itm),
        .no_match_o(no_match), .form_o(form), .status_o(status),
        .wide_qual_o(wide_qual), .rn_o(rn), .rt_o(rt), .rm_o(rm),
        .imm_o(imm), .shamt_o(shamt), .index_o(index_f), .add_o(add_f),
        .wback_o(wback_f)
    );

    typedef struct packed {
        logic        nm;
        logic [3:0]  fm;
        logic [1:0]  st;
        logic        wq;
        logic [3:0]  bn, dt, of;
        logic [31:0] iv;
        logic [1:0]  sh;
        logic        ix, ad, wb;
    } exp_t;

    // Reference model written from the requirements.
    function automatic exp_t model(logic [31:0] w, logic wd, logic im);
        exp_t e;
        logic [15:0] h;
        logic [2:0]  c;
        e = '0;
        h = w[15:0];
        if (!wd) begin
            if (h[15:11] == 5'b01101) begin          // R1
                e.fm = 1; e.dt = {1'b0, h[2:0]}; e.bn = {1'b0, h[5:3]};
                e.iv = {25'd0, h[10:6], 2'b00}; e.ix = 1; e.ad = 1;
            end else if (h[15:11] == 5'b10011) begin // R2
                e.fm = 2; e.bn = 13; e.dt = {1'b0, h[10:8]};
                e.iv = {22'd0, h[7:0], 2'b00}; e.ix = 1; e.ad = 1;
            end else if (h[15:11] == 5'b01001) begin // R3
                e.fm = 3; e.bn = 15; e.dt = {1'b0, h[10:8]};
                e.iv = {22'd0, h[7:0], 2'b00}; e.ix = 1; e.ad = 1;
            end else if (h[15:9] == 7'b0101100) begin // R7
                e.fm = 4; e.of = {1'b0, h[8:6]}; e.bn = {1'b0, h[5:3]};
                e.dt = {1'b0, h[2:0]}; e.ix = 1; e.ad = 1;
            end
        end else begin
            e.dt = w[15:12];
            if (w[31:24] == 8'hF8 && w[22:16] == 7'h5F) begin
                e.fm = 7; e.bn = 15; e.iv = {20'd0, w[11:0]}; e.ix = 1; e.ad = w[23];
                if (e.dt == 15 && im) e.st = 3;
            end else if (w[31:20] == 12'hF8D) begin
                e.fm = 5; e.bn = w[19:16]; e.iv = {20'd0, w[11:0]}; e.ix = 1; e.ad = 1;
                if (e.dt == 15 && im) e.st = 3;
            end else if (w[31:20] == 12'hF85 && w[11]) begin
                c = w[10:8];
                e.fm = 6; e.bn = w[19:16]; e.iv = {24'd0, w[7:0]};
                e.ix = c[2]; e.ad = c[1]; e.wb = c[0];
                if (c == 3'b110 || (e.bn == 13 && c == 3'b011 && w[7:0] == 8'd4)) e.st = 1;
                else if (c[2] == 0 && c[0] == 0) e.st = 2;
                else if ((c[0] && e.bn == e.dt) || (e.dt == 15 && im)) e.st = 3;
            end else if (w[31:20] == 12'hF85 && w[11:6] == 0) begin
                e.fm = 8; e.bn = w[19:16]; e.of = w[3:0]; e.sh = w[5:4]; e.ix = 1; e.ad = 1;
                if (e.of == 13 || e.of == 15 || (e.dt == 15 && im)) e.st = 3;
            end
        end
        if (e.fm == 0) e = '0;
        e.nm = (e.fm == 0);
        e.wq = (e.fm == 5 || e.fm == 7 || e.fm == 8);   // R10
        return e;
    endfunction

    task automatic check(string tag, exp_t exp);
        exp_t act;
        act = {no_match, form, status, wide_qual, rn, rt, rm, imm, shamt, index_f, add_f, wback_f};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s insn=%h wide=%0b it=%0b actual=%h expected=%h",
                     tag, insn, wide, itm, act, exp);
        end
    endtask

    task automatic apply(string tag, logic [31:0] w, logic wd, logic im);
        @(posedge clk);
        insn = w; wide = wd; itm = im;
        @(negedge clk);
        check(tag, model(w, wd, im));
    endtask

    // Check one status value directly, independent of the model.
    task automatic apply_st(string tag, logic [31:0] w, logic wd, logic im,
                            logic [3:0] efm, logic [1:0] est);
        apply(tag, w, wd, im);
        n_checks++;
        if (form !== efm || status !== est) begin
            n_fail++;
            $display("FAIL %s form/status actual=%0d/%0d expected=%0d/%0d",
                     tag, form, status, efm, est);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        insn = '0; wide = 0; itm = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Zero 16-bit halfword matches nothing: R9
        check("R9 reset-state nomatch", model(32'd0, 1'b0, 1'b0));
        if (no_match !== 1'b1) begin
            n_checks++; n_fail++;
            $display("FAIL R9 no_match actual=%0b expected=1", no_match);
        end

        // Directed corner cases.
        apply_st("R1 imm5",            32'hFFFF_6FFF, 0, 1, 4'd1, 2'd0);
        apply_st("R2 sp8",             32'h0000_9AFF, 0, 0, 4'd2, 2'd0);
        apply_st("R3 lit8",            32'h1234_4F80, 0, 1, 4'd3, 2'd0);
        apply_st("R7 reg16",           32'h0000_59D1, 0, 0, 4'd4, 2'd0);
        apply_st("R5 pop alias other", 32'hF85D_3B04, 1, 0, 4'd6, 2'd1);
        apply_st("R5 puw110 other",    32'hF851_2E10, 1, 0, 4'd6, 2'd1);
        apply_st("R5 puw000 undef",    32'hF851_2810, 1, 0, 4'd6, 2'd2);
        apply_st("R5 puw010 undef",    32'hF851_2A10, 1, 1, 4'd6, 2'd2);
        apply_st("R6 wback rn==rt",    32'hF852_2D08, 1, 0, 4'd6, 2'd3);
        apply_st("R6 pop-like imm8=8", 32'hF85D_3B08, 1, 0, 4'd6, 2'd0);
        apply_st("R6 rt=pc in block",  32'hF8D1_F004, 1, 1, 4'd5, 2'd3);
        apply_st("R6 rt=pc last",      32'hF8D1_F004, 1, 0, 4'd5, 2'd0);
        apply_st("R6 reg32 rm=sp",     32'hF851_203D, 1, 0, 4'd8, 2'd3);
        apply_st("R7 reg32 shift3",    32'hF851_2034, 1, 0, 4'd8, 2'd0);
        apply_st("R3 imm12 base pc is literal", 32'hF8DF_1123, 1, 0, 4'd7, 2'd0);
        apply_st("R3 lit12 subtract",  32'hF85F_1123, 1, 0, 4'd7, 2'd0);
        apply_st("R8 16-bit ignores it", 32'h0000_6FFF, 0, 1, 4'd1, 2'd0);
        apply("R9 32-bit nomatch",     32'hF850_2440, 1, 0);
        apply("R9 16-bit upper ignored", 32'hF8D1_0000, 0, 0);
        apply("R10 qual imm12",        32'hF8D3_4567, 1, 0);
        apply("R4 imm12 max",          32'hF8D0_0FFF, 1, 0);

        // Constrained random: force a form's prefix, randomise free fields.
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [31:0] r;
            logic [31:0] w;
            logic wd;
            string tag;
            k = $urandom_range(0, 8);
            r = $urandom;
            case (k)
                1: begin w = {r[31:16], 5'b01101, r[10:0]}; wd = 0; tag = "R1 rand"; end
                2: begin w = {r[31:16], 5'b10011, r[10:0]}; wd = 0; tag = "R2 rand"; end
                3: begin w = {r[31:16], 5'b01001, r[10:0]}; wd = 0; tag = "R3 rand"; end
                4: begin w = {r[31:16], 7'b0101100, r[8:0]}; wd = 0; tag = "R7 rand16"; end
                5: begin w = {12'hF8D, r[19:0]}; wd = 1; tag = "R4 rand"; end
                6: begin w = {12'hF85, r[19:12], 1'b1, r[10:0]}; wd = 1; tag = "R5 rand"; end
                7: begin w = {8'hF8, r[23], 7'h5F, r[15:0]}; wd = 1; tag = "R3 rand32"; end
                8: begin w = {12'hF85, r[19:12], 6'd0, r[5:0]}; wd = 1; tag = "R7 rand32"; end
                default: begin w = r; wd = r[7]; tag = "R9 rand any"; end
            endcase
            apply(tag, w, wd, 1'($urandom_range(0, 1)));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule